// File: doc/BRIEF.md
# Memory-to-Video Copy Engine

This block moves a run of bytes from system RAM into video memory without the CPU touching each byte. Software loads a source RAM address, a destination video address, a 16-bit byte count and an inter-write gap, then sets a start bit. While the transfer runs, software only polls a busy flag. The engine reads RAM through a synchronous read port with one cycle of latency and sends each byte to video memory over a valid/ready write stream. Addresses advance by one per byte, so a single transfer can span many 256-byte pages.

Because the video target cannot take a write on every cycle, the engine holds back each write until a programmed number of idle cycles has passed since the previous accepted write. A gap of zero allows one write per cycle. A two-entry prefetch buffer lets the next RAM read overlap the current write, so the RAM latency never limits throughput. Data only moves from RAM toward video memory.

Back-pressure rules on the video stream: a beat transfers on a rising edge where `vid_valid` and `vid_ready` are both high. Once `vid_valid` is raised it stays high, with `vid_addr` and `vid_data` unchanged, until that beat is accepted. `vid_valid` never depends on `vid_ready`. While the sink stalls, the engine stops issuing RAM reads once the buffer is full, and it drops no byte.

Top module: `vcopy_engine`

## Requirements
- R1: The register map is as follows. Index 0 holds the source address. Index 1 holds the destination address. Index 2 holds the count. Index 3 holds the gap. Index 4 is the control/status register. A write to index 0 to 3 is accepted only while busy is low, and reads return the programmed value, zero-extended. Reading index 4 returns busy in bit 0 and done in bit 1. After reset every register reads 0.
- R2: Writing index 4 with bit 0 set, while idle and with a nonzero count, raises busy on the next cycle. Busy stays high until the last byte's write is accepted and falls on the cycle after that acceptance.
- R3: A start with a count of 0 never raises busy. It sets done on the next cycle, and it produces no RAM read and no video write.
- R4: A start written while busy is ignored. The running transfer finishes with its original parameters and its original number of writes.
- R5: A transfer of N bytes makes exactly N accepted video writes, in ascending address order. Write i carries address dst+i and the RAM byte at src+i.
- R6: `ram_rd_en` is a one-cycle request, and its data is valid on `ram_rd_data` in the next cycle. While busy is low, neither `ram_rd_en` nor `vid_valid` is asserted.
- R7: Two consecutive accepted writes are at least gap+1 cycles apart. With a gap of 0 and `vid_ready` held high, the writes are accepted on consecutive cycles.
- R8: While `vid_valid` is high and `vid_ready` is low, the next cycle still has `vid_valid` high with the same `vid_addr` and `vid_data`.
- R9: Done is sticky. It is set when a transfer completes. It is cleared by a start write (bit 0 of index 4) or by writing index 4 with bit 1 set.
- R10: The 16-bit count allows one transfer to carry more than 256 bytes. The source and destination addresses carry across page boundaries on their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| ram_rd_en | output | 1 | RAM read request |
| ram_rd_addr | output | 16 | RAM read address |
| ram_rd_data | input | 8 | RAM read data, one cycle after the request |
| vid_valid | output | 1 | Video write beat valid |
| vid_ready | input | 1 | Video target accepts the beat |
| vid_addr | output | 17 | Video write address |
| vid_data | output | 8 | Video write byte |

## Verification
A fault in the source counter or the read-issue logic shows up at the ports as a wrong byte. The bench catches this on the first mismatching destination address, which it compares against its RAM model once the transfer ends. A fault in the gap counter or the buffer occupancy shows up as two accepted writes closer together than gap+1 cycles. It can also show as a beat that changes during a stall, which the bench flags in the cycle where it happens. A remaining-count fault shows as an extra or missing write, or as busy falling in some cycle other than the one after the last acceptance. Each of these is visible when that transfer completes.

// File: rtl/vcopy_pkg.sv
package vcopy_pkg;
  localparam int RIDX_W = 3;
  localparam int REG_DW = 32;

  localparam logic [RIDX_W-1:0] IDX_SRC = 3'd0;
  localparam logic [RIDX_W-1:0] IDX_DST = 3'd1;
  localparam logic [RIDX_W-1:0] IDX_CNT = 3'd2;
  localparam logic [RIDX_W-1:0] IDX_GAP = 3'd3;
  localparam logic [RIDX_W-1:0] IDX_CTL = 3'd4;

  localparam int CTL_GO_BIT  = 0;
  localparam int CTL_CLR_BIT = 1;
  localparam int STS_BUSY_BIT = 0;
  localparam int STS_DONE_BIT = 1;
endpackage

// File: rtl/vcopy_regs.sv
module vcopy_regs
  import vcopy_pkg::*;
#(
  parameter int SRC_AW = 16,
  parameter int DST_AW = 17,
  parameter int CNT_W  = 16,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RIDX_W-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              last_fire,
  output logic              go,
  output logic              busy,
  output logic              done,
  output logic [SRC_AW-1:0] src_q,
  output logic [DST_AW-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [GAP_W-1:0]  gap_q
);
  logic busy_q, done_q;
  logic ctl_wr, cfg_wr, start_req;

  assign ctl_wr    = reg_we && (reg_addr == IDX_CTL);
  assign cfg_wr    = reg_we && !busy_q;
  assign start_req = ctl_wr && reg_wdata[CTL_GO_BIT] && !busy_q;
  assign go        = start_req && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      gap_q <= '0;
    end else if (cfg_wr) begin
      case (reg_addr)
        IDX_SRC: src_q <= reg_wdata[SRC_AW-1:0];
        IDX_DST: dst_q <= reg_wdata[DST_AW-1:0];
        IDX_CNT: cnt_q <= reg_wdata[CNT_W-1:0];
        IDX_GAP: gap_q <= reg_wdata[GAP_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (go)             busy_q <= 1'b1;
      else if (last_fire) busy_q <= 1'b0;

      if (start_req)      done_q <= (cnt_q == '0);
      else if (last_fire) done_q <= 1'b1;
      else if (ctl_wr && reg_wdata[CTL_CLR_BIT]) done_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      IDX_SRC: reg_rdata = REG_DW'(src_q);
      IDX_DST: reg_rdata = REG_DW'(dst_q);
      IDX_CNT: reg_rdata = REG_DW'(cnt_q);
      IDX_GAP: reg_rdata = REG_DW'(gap_q);
      IDX_CTL: begin
        reg_rdata[STS_BUSY_BIT] = busy_q;
        reg_rdata[STS_DONE_BIT] = done_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> !busy_q); // R2
  AST_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && cnt_q == '0) |=> (!busy_q && done_q)); // R3
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !ctl_wr) |=> done_q); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q) && $stable(gap_q))); // R1
endmodule

// File: rtl/vcopy_reader.sv
module vcopy_reader #(
  parameter int SRC_AW = 16,
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 2,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              busy,
  input  logic [SRC_AW-1:0] src_start,
  input  logic [CNT_W-1:0]  cnt_start,
  input  logic [OCC_W-1:0]  buf_cnt,
  input  logic              fire,
  output logic              ram_rd_en,
  output logic [SRC_AW-1:0] ram_rd_addr,
  output logic              rd_pend
);
  logic [SRC_AW-1:0] rd_ptr;
  logic [CNT_W-1:0]  rd_left;
  logic              room;

  // Room exists when the held bytes plus the byte in flight, less the one leaving now, fit.
  assign room      = (int'(buf_cnt) + int'(rd_pend)) < (DEPTH + int'(fire));
  assign ram_rd_en = busy && (rd_left != '0) && room;
  assign ram_rd_addr = rd_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      rd_left <= '0;
      rd_pend <= 1'b0;
    end else begin
      rd_pend <= ram_rd_en;
      if (go) begin
        rd_ptr  <= src_start;
        rd_left <= cnt_start;
      end else if (ram_rd_en) begin
        rd_ptr  <= rd_ptr + 1'b1;
        rd_left <= rd_left - 1'b1;
      end
    end
  end

  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ram_rd_en); // R6
  AST_RD_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_left == '0 && !go) |=> !ram_rd_en); // R5
endmodule

// File: rtl/vcopy_fifo.sv
module vcopy_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [DW-1:0]    head,
  output logic [OCC_W-1:0] occ
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: ;
      endcase
    end
  end

  assign head = mem[rp];

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && int'(occ) == DEPTH) |-> pop); // R5
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (occ != '0)); // R5
endmodule

// File: rtl/vcopy_writer.sv
module vcopy_writer #(
  parameter int DW     = 8,
  parameter int DST_AW = 17,
  parameter int CNT_W  = 16,
  parameter int GAP_W  = 8,
  parameter int DEPTH  = 2,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              busy,
  input  logic [DST_AW-1:0] dst_start,
  input  logic [CNT_W-1:0]  cnt_start,
  input  logic [GAP_W-1:0]  gap,
  input  logic [OCC_W-1:0]  buf_cnt,
  input  logic [DW-1:0]     buf_head,
  input  logic              vid_ready,
  output logic              vid_valid,
  output logic [DST_AW-1:0] vid_addr,
  output logic [DW-1:0]     vid_data,
  output logic              fire,
  output logic              last_fire
);
  logic [DST_AW-1:0] wr_ptr;
  logic [CNT_W-1:0]  wr_left;
  logic [GAP_W-1:0]  hold_cnt;

  assign vid_valid = busy && (buf_cnt != '0) && (hold_cnt == '0);
  assign vid_addr  = wr_ptr;
  assign vid_data  = buf_head;
  assign fire      = vid_valid && vid_ready;
  assign last_fire = fire && (wr_left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      wr_left  <= '0;
      hold_cnt <= '0;
    end else if (go) begin
      wr_ptr   <= dst_start;
      wr_left  <= cnt_start;
      hold_cnt <= '0;
    end else if (fire) begin
      wr_ptr   <= wr_ptr + 1'b1;
      wr_left  <= wr_left - 1'b1;
      hold_cnt <= gap;
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end

  // Independent spacing monitor: cycles elapsed since the last accepted beat.
  logic [GAP_W:0] since_fire;
  logic           seen_fire;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_fire <= '0;
      seen_fire  <= 1'b0;
    end else if (go) begin
      seen_fire  <= 1'b0;
      since_fire <= '0;
    end else if (fire) begin
      seen_fire  <= 1'b1;
      since_fire <= '0;
    end else if (since_fire != '1) begin
      since_fire <= since_fire + 1'b1;
    end
  end

  AST_GAP_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && seen_fire) |-> (since_fire >= {1'b0, gap})); // R7
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_valid && !vid_ready) |=> (vid_valid && $stable(vid_addr) && $stable(vid_data))); // R8
  AST_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !vid_valid); // R6
endmodule

// File: rtl/vcopy_engine.sv
module vcopy_engine
  import vcopy_pkg::*;
#(
  parameter int DW     = 8,
  parameter int SRC_AW = 16,
  parameter int DST_AW = 17,
  parameter int CNT_W  = 16,
  parameter int GAP_W  = 8,
  parameter int DEPTH  = 2,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RIDX_W-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              busy,
  output logic              done,
  output logic              ram_rd_en,
  output logic [SRC_AW-1:0] ram_rd_addr,
  input  logic [DW-1:0]     ram_rd_data,
  output logic              vid_valid,
  input  logic              vid_ready,
  output logic [DST_AW-1:0] vid_addr,
  output logic [DW-1:0]     vid_data
);
  logic              go, fire, last_fire, rd_pend;
  logic [SRC_AW-1:0] src_q;
  logic [DST_AW-1:0] dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [GAP_W-1:0]  gap_q;
  logic [OCC_W-1:0]  buf_cnt;
  logic [DW-1:0]     buf_head;

  vcopy_regs #(
    .SRC_AW(SRC_AW), .DST_AW(DST_AW), .CNT_W(CNT_W), .GAP_W(GAP_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .last_fire(last_fire),
    .go(go), .busy(busy), .done(done), .src_q(src_q), .dst_q(dst_q),
    .cnt_q(cnt_q), .gap_q(gap_q)
  );

  vcopy_reader #(
    .SRC_AW(SRC_AW), .CNT_W(CNT_W), .DEPTH(DEPTH)
  ) u_reader (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .src_start(src_q),
    .cnt_start(cnt_q), .buf_cnt(buf_cnt), .fire(fire),
    .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr), .rd_pend(rd_pend)
  );

  vcopy_fifo #(
    .DW(DW), .DEPTH(DEPTH)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .push(rd_pend), .push_data(ram_rd_data),
    .pop(fire), .head(buf_head), .occ(buf_cnt)
  );

  vcopy_writer #(
    .DW(DW), .DST_AW(DST_AW), .CNT_W(CNT_W), .GAP_W(GAP_W), .DEPTH(DEPTH)
  ) u_writer (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .dst_start(dst_q),
    .cnt_start(cnt_q), .gap(gap_q), .buf_cnt(buf_cnt), .buf_head(buf_head),
    .vid_ready(vid_ready), .vid_valid(vid_valid), .vid_addr(vid_addr),
    .vid_data(vid_data), .fire(fire), .last_fire(last_fire)
  );

  AST_RD_NOT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> !ram_rd_en); // R5
endmodule

// File: tb/tb_vcopy_engine.sv
module tb_vcopy_engine;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_N = 4096;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy, done, ram_rd_en, vid_valid;
  logic [15:0] ram_rd_addr;
  logic [7:0]  ram_rd_data, vid_data;
  logic [16:0] vid_addr;
  logic        vid_ready = 1'b1;

  vcopy_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
    .vid_valid(vid_valid), .vid_ready(vid_ready), .vid_addr(vid_addr),
    .vid_data(vid_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [7:0] ram  [MEM_N];
  logic [7:0] vmem [MEM_N];
  logic [7:0] ram_q = '0;
  assign ram_rd_data = ram_q;
  always @(posedge clk) if (ram_rd_en) ram_q <= ram[ram_rd_addr[11:0]];

  // ready pattern
  logic       rdy_rand = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    vid_ready <= rdy_rand ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // monitor, sampled at the falling edge
  int          cyc = 0;
  int          wcount, addr_err, hold_err, idle_err, last_fire_cyc, min_sp, max_sp;
  logic [16:0] exp_addr;
  logic        p_stall = 1'b0;
  logic [16:0] p_addr;
  logic [7:0]  p_data;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_stall && (!vid_valid || vid_addr != p_addr || vid_data != p_data)) hold_err++;
      if (!busy && (vid_valid || ram_rd_en)) idle_err++;
      if (vid_valid && vid_ready) begin
        if (vid_addr != exp_addr) addr_err++;
        vmem[vid_addr[11:0]] = vid_data;
        if (wcount > 0) begin
          if (cyc - last_fire_cyc < min_sp) min_sp = cyc - last_fire_cyc;
          if (cyc - last_fire_cyc > max_sp) max_sp = cyc - last_fire_cyc;
        end
        last_fire_cyc = cyc;
        exp_addr = exp_addr + 17'd1;
        wcount++;
      end
      p_stall = vid_valid && !vid_ready;
      p_addr  = vid_addr;
      p_data  = vid_data;
    end
    if (cyc > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  task automatic mon_clear(input logic [16:0] dst);
    wcount = 0; addr_err = 0; hold_err = 0; idle_err = 0;
    min_sp = 1 << 30; max_sp = 0; last_fire_cyc = 0; exp_addr = dst;
    for (int i = 0; i < MEM_N; i++) vmem[i] = 8'h00;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 20000) begin
      step(1); t++;
    end
  endtask

  task automatic run_copy(input string tag, input logic [15:0] src, input logic [16:0] dst,
                          input int cnt, input int gap, input logic rmode);
    int bad = 0;
    logic [31:0] v;
    rdy_rand = rmode;
    wr(3'd0, 32'(src)); wr(3'd1, 32'(dst)); wr(3'd2, 32'(cnt)); wr(3'd3, 32'(gap));
    mon_clear(dst);
    wr(3'd4, 32'h1);
    check({tag, " R2 busy after start"}, 32'(busy), 32'd1);
    check({tag, " R9 done cleared by start"}, 32'(done), 32'd0);
    wait_idle();
    check({tag, " R2 busy falls after last write"}, 32'(cyc), 32'(last_fire_cyc + 1));
    check({tag, " R5 write count"}, 32'(wcount), 32'(cnt));
    check({tag, " R5 ascending addresses"}, 32'(addr_err), 32'd0);
    for (int i = 0; i < cnt; i++)
      if (vmem[(int'(dst) + i) % MEM_N] !== ram[(int'(src) + i) % MEM_N]) bad++;
    check({tag, " R5 R10 data match"}, 32'(bad), 32'd0);
    if (cnt > 1) check({tag, " R7 min spacing"}, 32'(min_sp >= gap + 1), 32'd1);
    if (cnt > 1 && gap == 0 && !rmode) check({tag, " R7 back-to-back"}, 32'(max_sp), 32'd1);
    check({tag, " R8 held beats"}, 32'(hold_err), 32'd0);
    check({tag, " R6 quiet when idle"}, 32'(idle_err), 32'd0);
    check({tag, " R9 done set"}, 32'(done), 32'd1);
    rd(3'd4, v);
    check({tag, " R1 status readback"}, v, 32'h2);
    rdy_rand = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 reset busy", 32'(busy), 32'd0);
    check("R1 reset done", 32'(done), 32'd0);
    check("R6 reset no read", 32'(ram_rd_en), 32'd0);
    check("R6 reset no write", 32'(vid_valid), 32'd0);
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), v);
      check("R1 reset register", v, 32'd0);
    end
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_1234); wr(3'd1, 32'hFFFF_FFFF); wr(3'd2, 32'h0001_0203); wr(3'd3, 32'h0000_0107);
    rd(3'd0, v); check("R1 src readback", v, 32'h1234);
    rd(3'd1, v); check("R1 dst readback", v, 32'h1FFFF);
    rd(3'd2, v); check("R1 count readback", v, 32'h0203);
    rd(3'd3, v); check("R1 gap readback", v, 32'h07);
  endtask

  task automatic t_zero();
    int t0;
    wr(3'd2, 32'd0);
    mon_clear(17'd0);
    wr(3'd4, 32'h1);
    check("R3 zero count busy", 32'(busy), 32'd0);
    check("R3 zero count done", 32'(done), 32'd1);
    t0 = 0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      if (busy) t0++;
    end
    check("R3 zero count stays idle", 32'(t0), 32'd0);
    check("R3 zero count no writes", 32'(wcount), 32'd0);
    check("R6 zero count no reads", 32'(idle_err), 32'd0);
  endtask

  task automatic t_clear();
    wr(3'd4, 32'h2);
    check("R9 clear by bit 1", 32'(done), 32'd0);
    wr(3'd4, 32'h0);
    check("R9 no spurious set", 32'(done), 32'd0);
  endtask

  task automatic t_start_busy();
    logic [31:0] v;
    int bad = 0;
    wr(3'd0, 32'h200); wr(3'd1, 32'h300); wr(3'd2, 32'd40); wr(3'd3, 32'd2);
    mon_clear(17'h300);
    wr(3'd4, 32'h1);
    step(10);
    wr(3'd0, 32'h555); wr(3'd2, 32'd5); wr(3'd4, 32'h1);
    rd(3'd0, v); check("R1 src ignored while busy", v, 32'h200);
    rd(3'd2, v); check("R4 count ignored while busy", v, 32'd40);
    wait_idle();
    check("R4 original write count", 32'(wcount), 32'd40);
    for (int i = 0; i < 40; i++) if (vmem['h300 + i] !== ram['h200 + i]) bad++;
    check("R4 original data", 32'(bad), 32'd0);
    check("R7 gap 2 spacing", 32'(min_sp >= 3), 32'd1);
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) ram[i] = 8'(i * 37 + (i >> 8) + 5);
    mon_clear(17'd0);
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_readback();
    run_copy("basic", 16'h0010, 17'h00040, 16, 0, 1'b0);
    run_copy("gap3", 16'h0100, 17'h00800, 12, 3, 1'b0);
    run_copy("stall", 16'h0400, 17'h00A00, 50, 0, 1'b1);
    run_copy("stallgap", 16'h0500, 17'h00C00, 30, 1, 1'b1);
    run_copy("single", 16'h0777, 17'h00123, 1, 5, 1'b0);
    run_copy("R10 pages", 16'h00F0, 17'h10F80, 300, 0, 1'b0);
    t_zero();
    t_clear();
    t_start_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule